// File: doc/BRIEF.md
# Nickel-Dime Vending Controller

This block tracks the money put into a single coin slot that takes nickels and dimes. It releases the item once at least fifteen cents have gone in, and it gives no change. Each coin detector pulses its own strobe for one clock cycle. The controller moves through four credit levels: 0, 5, 10 and 15 cents. When the credit reaches fifteen cents, the controller holds the chute-open output high. It stays there until a reset starts the next sale.

Two parameters choose how the block is built. `ONE_HOT` selects the state encoding. With the default of 0, the credit is held as a two-bit binary code. With 1, the credit is held as four flags, exactly one of them set. `RETIMED` selects how the open signal is produced. With 0, open is decoded from the state registers (a Moore output). With the default of 1, open has its own flip-flop, loaded from the next-state credit. Both choices give the same cycle timing at the port. The registered form has no decode logic after the state flip-flops.

Top module: `vend_ctrl_top`

## Requirements
- R1: Reset is synchronous and active high, and it overrides any coin strobe in the same cycle. After a reset edge the credit is 0 cents and `chuteOpen` is low.
- R2: A nickel strobe alone, sampled at a rising edge, adds 5 cents to the credit.
- R3: A dime strobe alone, sampled at a rising edge, adds 10 cents to the credit.
- R4: Credit saturates at 15 cents. A dime taken at 10 cents leads to 15 cents, not 20.
- R5: Once at 15 cents, the credit stays there under any coin inputs until reset.
- R6: In a cycle with no coin strobe, the credit is unchanged.
- R7: Nickel and dime asserted in the same cycle count as no coin, and the credit is unchanged.
- R8: `chuteOpen` is high exactly while the credit is 15 cents. It rises right after the clock edge that takes the credit to 15 cents, in both output variants.
- R9: With `ONE_HOT`=1, exactly one of the four state flags is set after reset. With `ONE_HOT`=0, the binary codes 00, 01, 10 and 11 stand for 0, 5, 10 and 15 cents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears credit |
| nickelIn | input | 1 | One-cycle strobe: a nickel was inserted |
| dimeIn | input | 1 | One-cycle strobe: a dime was inserted |
| chuteOpen | output | 1 | High while 15 cents of credit are held |

## Verification
The coin orders used are:
- three nickels
- nickel then dime
- dime then nickel
- two dimes

These four orders separate an adder that counts nickels correctly from one that counts dimes correctly. The two-dime case separates saturation from overflow or wrap-around. Idle gaps and double-coin cycles are placed between coins, and the following coins show whether the credit moved, since opening one coin too early or too late exposes any drift. Coins sent after fifteen cents, and a reset that arrives together with a dime at 10 cents, show whether the terminal hold and reset priority work. All four variants (both encodings, each with both output forms) get the same stimulus and must produce identical `chuteOpen` traces.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int CREDIT_STATES = 4;
  localparam int IDX_W = $clog2(CREDIT_STATES);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(CREDIT_STATES - 1);
  localparam logic [IDX_W-1:0] IDX_TEN = IDX_W'(CREDIT_STATES - 2);

  // Strobes from control to datapath; addFive and addTen are never both set.
  typedef struct packed {
    logic clear;
    logic addFive;
    logic addTen;
  } coinCmd_t;

  // Next credit index (index * 5 cents), saturating at IDX_FULL.
  function automatic logic [IDX_W-1:0] stepCredit(input logic [IDX_W-1:0] idx,
                                                  input coinCmd_t cmd);
    logic [IDX_W-1:0] res;
    if (cmd.clear) res = '0;
    else if (cmd.addTen) res = (idx >= IDX_TEN) ? IDX_FULL : idx + IDX_W'(2);
    else if (cmd.addFive) res = (idx == IDX_FULL) ? IDX_FULL : idx + IDX_W'(1);
    else res = idx;
    return res;
  endfunction

endpackage

// File: rtl/vend_credit_dp.sv
module vend_credit_dp
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic             clk,
  input  coinCmd_t         cmd,
  output logic [IDX_W-1:0] creditIdx,
  output logic             atFull,
  output logic             nextFull
);

  generate
    if (ONE_HOT) begin : g_onehot
      logic [CREDIT_STATES-1:0] hotQ;
      logic [CREDIT_STATES-1:0] hotNext;
      logic idle;

      assign idle = ~cmd.addFive & ~cmd.addTen;

      // Each flag depends only on its predecessor flags.
      always_comb begin
        hotNext[0] = cmd.clear | (hotQ[0] & idle);
        hotNext[1] = ~cmd.clear & ((hotQ[0] & cmd.addFive) | (hotQ[1] & idle));
        hotNext[2] = ~cmd.clear & ((hotQ[0] & cmd.addTen) | (hotQ[1] & cmd.addFive) |
                                   (hotQ[2] & idle));
        hotNext[3] = ~cmd.clear & (hotQ[3] | (hotQ[1] & cmd.addTen) |
                                   (hotQ[2] & (cmd.addFive | cmd.addTen)));
      end

      always_ff @(posedge clk) hotQ <= hotNext;

      always_comb begin
        creditIdx = '0;
        for (int i = 0; i < CREDIT_STATES; i++)
          if (hotQ[i]) creditIdx = IDX_W'(i);
      end

      assign atFull = hotQ[CREDIT_STATES-1];
      assign nextFull = hotNext[CREDIT_STATES-1];

      // R9: exactly one flag set once out of reset
      a_r9_onehot_valid: assert property (@(posedge clk) disable iff (cmd.clear)
        $onehot(hotQ));
    end else begin : g_binary
      logic [IDX_W-1:0] binQ;
      logic [IDX_W-1:0] binNext;

      assign binNext = stepCredit(binQ, cmd);
      always_ff @(posedge clk) binQ <= binNext;

      assign creditIdx = binQ;
      assign atFull = &binQ;
      assign nextFull = &binNext;
    end
  endgenerate

  // R1: reset empties the credit
  a_r1_reset_zero: assert property (@(posedge clk)
    cmd.clear |=> (creditIdx == '0));

  // R2: a nickel advances one step below the top
  a_r2_nickel_step: assert property (@(posedge clk) disable iff (cmd.clear)
    (cmd.addFive && creditIdx != IDX_FULL) |=> (creditIdx == $past(creditIdx) + IDX_W'(1)));

  // R3: a dime from zero or five cents advances two steps
  a_r3_dime_step: assert property (@(posedge clk) disable iff (cmd.clear)
    (cmd.addTen && creditIdx < IDX_TEN) |=> (creditIdx == $past(creditIdx) + IDX_W'(2)));

  // R4: a dime at ten cents lands on the top state
  a_r4_dime_saturates: assert property (@(posedge clk) disable iff (cmd.clear)
    (cmd.addTen && creditIdx == IDX_TEN) |=> (creditIdx == IDX_FULL));

  // R5: top state is kept until reset
  a_r5_full_holds: assert property (@(posedge clk) disable iff (cmd.clear)
    (creditIdx == IDX_FULL) |=> (creditIdx == IDX_FULL));

  // R6, R7: no coin command leaves the credit alone
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (cmd.clear)
    (!cmd.addFive && !cmd.addTen) |=> $stable(creditIdx));

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit RETIMED = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     nickelIn,
  input  logic     dimeIn,
  input  logic     atFull,
  input  logic     nextFull,
  output coinCmd_t cmd,
  output logic     chuteOpen
);

  // R7: both strobes together decode to no coin
  always_comb begin
    cmd.clear = rst;
    cmd.addFive = nickelIn & ~dimeIn;
    cmd.addTen = dimeIn & ~nickelIn;
  end

  generate
    if (RETIMED) begin : g_regOpen
      logic openQ;
      always_ff @(posedge clk) openQ <= ~rst & nextFull;
      assign chuteOpen = openQ;
    end else begin : g_mooreOpen
      assign chuteOpen = atFull;
    end
  endgenerate

  // R7: the datapath never sees two coin commands at once
  a_r7_single_coin: assert property (@(posedge clk) disable iff (rst)
    (nickelIn && dimeIn) |-> (!cmd.addFive && !cmd.addTen));

  // R8: open output follows the terminal state in either form
  a_r8_open_tracks: assert property (@(posedge clk) disable iff (rst)
    chuteOpen == atFull);

  // R1: reset closes the chute on the next cycle
  a_r1_reset_closes: assert property (@(posedge clk)
    rst |=> !chuteOpen);

endmodule

// File: rtl/vend_ctrl_top.sv
module vend_ctrl_top
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter bit RETIMED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic nickelIn,
  input  logic dimeIn,
  output logic chuteOpen
);

  coinCmd_t cmdBus;
  logic [IDX_W-1:0] creditIdx;
  logic atFull;
  logic nextFull;

  vend_ctrl #(.RETIMED(RETIMED)) ctrl_i (
    .clk(clk), .rst(rst), .nickelIn(nickelIn), .dimeIn(dimeIn),
    .atFull(atFull), .nextFull(nextFull), .cmd(cmdBus), .chuteOpen(chuteOpen)
  );

  vend_credit_dp #(.ONE_HOT(ONE_HOT)) dp_i (
    .clk(clk), .cmd(cmdBus), .creditIdx(creditIdx),
    .atFull(atFull), .nextFull(nextFull)
  );

endmodule

// File: tb/vend_ctrl_top_tb.sv
module vend_ctrl_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VARIANTS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickelIn = 1'b0;
  logic dimeIn = 1'b0;
  logic [VARIANTS-1:0] opens;
  int checks = 0;
  int failures = 0;
  int credit = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // variant v: bit0 = one-hot encoding, bit1 = registered open
  for (genvar v = 0; v < VARIANTS; v++) begin : g_var
    vend_ctrl_top #(.ONE_HOT((v % 2) == 1), .RETIMED((v / 2) == 1)) dut_i (
      .clk(clk), .rst(rst), .nickelIn(nickelIn), .dimeIn(dimeIn),
      .chuteOpen(opens[v])
    );
  end

  task automatic checkOpen(input string req);
    logic expOpen;
    expOpen = (credit >= 15);
    for (int v = 0; v < VARIANTS; v++) begin
      checks++;
      if (opens[v] !== expOpen) begin
        failures++;
        $display("FAIL %s variant %0d credit=%0d actual=%b expected=%b",
                 req, v, credit, opens[v], expOpen);
      end
    end
  endtask

  // drive one cycle of strobes at a falling edge, check after the next rise
  task automatic coin(input logic n, input logic d, input string req);
    @(negedge clk);
    nickelIn = n;
    dimeIn = d;
    @(negedge clk);
    nickelIn = 1'b0;
    dimeIn = 1'b0;
    if (n && !d) credit = (credit + 5 > 15) ? 15 : credit + 5;
    else if (d && !n) credit = (credit + 10 > 15) ? 15 : credit + 10;
    checkOpen(req);
  endtask

  task automatic doReset(input logic withDime, input string req);
    @(negedge clk);
    rst = 1'b1;
    dimeIn = withDime;
    @(negedge clk);
    rst = 1'b0;
    dimeIn = 1'b0;
    credit = 0;
    checkOpen(req);
  endtask

  task automatic t_threeNickels();
    coin(1, 0, "R2");
    coin(1, 0, "R2");
    coin(1, 0, "R8");
    doReset(0, "R1");
  endtask

  task automatic t_nickelDime();
    coin(1, 0, "R2");
    coin(0, 1, "R3");
    doReset(0, "R1");
  endtask

  task automatic t_dimeNickel();
    coin(0, 1, "R3");
    coin(1, 0, "R8");
    doReset(0, "R1");
  endtask

  task automatic t_twoDimes();
    coin(0, 1, "R3");
    coin(0, 1, "R4");
    coin(1, 0, "R5");
    coin(0, 1, "R5");
    coin(1, 1, "R5");
    coin(0, 0, "R5");
    doReset(0, "R1");
  endtask

  task automatic t_idleGaps();
    coin(1, 0, "R2");
    for (int i = 0; i < 5; i++) coin(0, 0, "R6");
    coin(1, 0, "R6");
    coin(0, 0, "R6");
    coin(1, 0, "R6");
    doReset(0, "R1");
  endtask

  task automatic t_bothStrobes();
    coin(1, 1, "R7");
    coin(1, 0, "R7");
    coin(1, 1, "R7");
    coin(1, 1, "R7");
    coin(1, 0, "R7");
    coin(1, 0, "R7");
    doReset(0, "R1");
  endtask

  task automatic t_resetPriority();
    coin(0, 1, "R3");
    doReset(1, "R1");
    coin(0, 1, "R1");
    coin(1, 0, "R1");
    doReset(0, "R1");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    credit = 0;
    checkOpen("R1");
    t_threeNickels();
    t_nickelDime();
    t_dimeNickel();
    t_twoDimes();
    t_idleGaps();
    t_bothStrobes();
    t_resetPriority();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule